// File: doc/BRIEF.md
# SPI Master Controller with Register Bus

This block is a serial peripheral interface master that a processor programs through a small 32-bit register bus. Software queues words in a transmit FIFO. The block shifts each word out on MOSI and, at the same time, collects the word arriving on MISO into a receive FIFO, so every transmitted word has a matching received word. Clock polarity, clock phase and bit order are set in a control register. The word width (8, 16 or 32 bits), the FIFO depth, the number of slave lines and the SCLK divider are parameters fixed at build time.

To refill the FIFO without a gap in mid-burst, software sets a hold bit that keeps the shifter from taking new words. Software then loads the FIFO and clears the bit, and the queued words go out one after another. Slave selects are active low. In manual mode they follow a register directly. In automatic mode the selected line is asserted only while a word is being shifted. An interrupt block has sticky event flags that software clears by writing ones, a per-event enable mask and a global gate. A keyed write to the reset register returns the whole block to its reset state. A slave-select input that is pulled low while the master is enabled is flagged as a mode fault. Slave operation is not implemented.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, control reads 0x180 (hold and manual select set), status reads 0x05 (both FIFOs empty), the slave-select register reads all ones, interrupt flags read 0, SCLK is low, every ss_n line is high and irq is low.
- R2: The control register is at byte offset 0x60. Its fields are enable (bit 1), master (bit 2), polarity (bit 3), phase (bit 4), flush TX (bit 5), flush RX (bit 6), manual select (bit 7), hold (bit 8) and LSB-first (bit 9). The flush bits empty their FIFO on the cycle of the write and always read back 0. Bit 0 always reads 0.
- R3: While hold (control bit 8) is 1, no word leaves the TX FIFO and SCLK does not toggle, but writes to the TX data offset 0x68 still queue words. Once hold is cleared, the queued words are shifted in order, each with exactly 2×width SCLK edges.
- R4: SCLK rests at the polarity bit. With phase 0, data is sampled on the edge leaving the rest level. With phase 1, data is sampled on the edge returning to it. In both cases the word received on MISO is the bit-for-bit image of what was sampled.
- R5: With LSB-first (control bit 9) at 0, bit width-1 is shifted out first. With it at 1, bit 0 is shifted out first. Received bits are placed with the same ordering.
- R6: The slave-select register is at offset 0x70 and is active low, one bit per line. With manual select at 1, ss_n equals the register at all times. With manual select at 0, ss_n is all ones except while a word is being shifted, and it returns high after each word.
- R7: Each completed word pushes one entry into the RX FIFO. A read at offset 0x6C returns the oldest entry and removes it. A read of an empty RX FIFO returns 0 and leaves the status unchanged.
- R8: Status (offset 0x64) reports RX empty (bit 0), RX full (bit 1), TX empty (bit 2), TX full (bit 3) and mode fault (bit 4). A write to a full TX FIFO is dropped.
- R9: A word that completes while the RX FIFO is full is discarded and sets the RX-overrun flag (interrupt bit 5). The entries already stored are kept.
- R10: The interrupt flags at offset 0x20 are mode fault (bit 0), slave-mode fault (bit 1), TX empty (bit 2), TX underrun (bit 3, reserved for slave operation, reads 0), RX became full (bit 4), RX overrun (bit 5) and TX fell to half depth or less (bit 6). Each flag stays set until a 1 is written to its bit.
- R11: The TX-empty flag is set only when a word finishes shifting and the TX FIFO is empty at that moment. The FIFO going empty while the last word is still in flight does not set it.
- R12: irq is the registered OR of (flags AND enable mask at 0x28), gated by bit 31 of the global gate at 0x1C. It follows a change of these registers one clock later.
- R13: Writing 0x0A to offset 0x40 resets every register and both FIFOs. Any other value written there is ignored.
- R14: With enable and master set, a low level on sel_in_n sets status bit 4 (cleared by reading status) and interrupt bit 0. With enable clear, a low level sets interrupt bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata the next cycle |
| bus_rdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_N | Active-low slave selects |
| sel_in_n | input | 1 | Active-low select sense input used for fault detection |
| irq | output | 1 | Interrupt request |

## Verification
A mis-stepped edge counter or shift register in the shifter shows up within a single word: the sampled MOSI pattern and the word read back over the loop from MOSI to MISO no longer match the queued value, and the SCLK edge count per word is wrong. A FIFO pointer or count error appears as soon as its FIFO is drained or filled: entries come back out of order or duplicated, or the full and empty status bits disagree with the number of words written. A wrong flag or gate bit is visible on irq one clock after the register that feeds it changes. A select line held in the wrong state is visible directly on ss_n during or just after a burst.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // register byte offsets
  localparam logic [7:0] A_GIE  = 8'h1C;
  localparam logic [7:0] A_ISR  = 8'h20;
  localparam logic [7:0] A_IER  = 8'h28;
  localparam logic [7:0] A_SRST = 8'h40;
  localparam logic [7:0] A_CR   = 8'h60;
  localparam logic [7:0] A_SR   = 8'h64;
  localparam logic [7:0] A_TXD  = 8'h68;
  localparam logic [7:0] A_RXD  = 8'h6C;
  localparam logic [7:0] A_SSR  = 8'h70;

  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  // control bit positions
  localparam int CB_EN    = 1;
  localparam int CB_MST   = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXRST = 5;
  localparam int CB_RXRST = 6;
  localparam int CB_MANSS = 7;
  localparam int CB_INH   = 8;
  localparam int CB_LSB   = 9;

  // interrupt flag positions
  localparam int IB_MODF  = 0;
  localparam int IB_SMODF = 1;
  localparam int IB_TXE   = 2;
  localparam int IB_TXUR  = 3;
  localparam int IB_RXF   = 4;
  localparam int IB_RXOV  = 5;
  localparam int IB_TXHE  = 6;
  localparam int NIRQ     = 7;

  typedef struct packed {
    logic lsb;
    logic inh;
    logic manss;
    logic cpha;
    logic cpol;
    logic mst;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} shift_st_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rptr];

  // storage has no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: a push into a full FIFO leaves the fill level alone
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (count == $past(count)));

  // R7: a pop from an empty FIFO leaves it empty
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CLK_DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [DW-1:0] word_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          lsb_i,
  input  logic          miso_i,
  output logic          take_o,
  output logic          done_o,
  output logic [DW-1:0] rx_word_o,
  output logic          active_o,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          mosi_o
);
  localparam int EW  = $clog2(2 * DW);
  localparam int DVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  shift_st_t      st;
  logic [DVW-1:0] div;
  logic [EW-1:0]  ecnt;
  logic [DW-1:0]  tx_sh, rx_sh, rx_nxt;
  logic           sclk_q;
  logic           start, tick, lead, last, samp, shft;

  always_comb begin
    start  = (st == S_IDLE) & go_i;
    tick   = (st == S_RUN) & (div == DVW'(CLK_DIV - 1));
    lead   = ~ecnt[0];
    last   = tick & (ecnt == EW'(2 * DW - 1));
    samp   = tick & (lead ^ cpha_i);
    shft   = tick & ~(lead ^ cpha_i) & (ecnt != '0);
    rx_nxt = lsb_i ? {miso_i, rx_sh[DW-1:1]} : {rx_sh[DW-2:0], miso_i};
  end

  assign take_o    = start;
  assign done_o    = last;
  assign rx_word_o = cpha_i ? rx_nxt : rx_sh;
  assign active_o  = start | (st == S_RUN);
  assign busy_o    = (st != S_IDLE);
  assign sclk_o    = sclk_q;
  assign mosi_o    = lsb_i ? tx_sh[0] : tx_sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      div    <= '0;
      ecnt   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sclk_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          sclk_q <= cpol_i;
          if (go_i) begin
            tx_sh <= word_i;
            div   <= '0;
            ecnt  <= '0;
            st    <= S_RUN;
          end
        end
        S_RUN: begin
          if (tick) begin
            div    <= '0;
            sclk_q <= ~sclk_q;
            ecnt   <= ecnt + 1'b1;
            if (samp) rx_sh <= rx_nxt;
            if (shft) tx_sh <= lsb_i ? (tx_sh >> 1) : (tx_sh << 1);
            if (last) st <= S_TAIL;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4: between words the clock rests at the programmed polarity
  p_idle_level_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && $past(st == S_IDLE) && $stable(cpol_i)) |-> (sclk_o == cpol_i));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DEPTH   = 16,
  parameter int SS_N    = 4,
  parameter int CLK_DIV = 4,
  parameter int AW      = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_rd,
  output logic [31:0]     bus_rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [SS_N-1:0] ss_n,
  input  logic            sel_in_n,
  output logic            irq
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  // keyed software reset, applied one cycle after the write
  logic soft_q, rst_i;
  always_ff @(posedge clk) begin
    if (rst) soft_q <= 1'b0;
    else     soft_q <= bus_wr && (bus_addr == AW'(A_SRST)) && (bus_wdata == SRST_KEY);
  end
  assign rst_i = rst | soft_q;

  logic wr_cr, wr_txd, wr_ssr, wr_gie, wr_isr, wr_ier, rd_rxd, rd_sr;
  assign wr_cr  = bus_wr && (bus_addr == AW'(A_CR));
  assign wr_txd = bus_wr && (bus_addr == AW'(A_TXD));
  assign wr_ssr = bus_wr && (bus_addr == AW'(A_SSR));
  assign wr_gie = bus_wr && (bus_addr == AW'(A_GIE));
  assign wr_isr = bus_wr && (bus_addr == AW'(A_ISR));
  assign wr_ier = bus_wr && (bus_addr == AW'(A_IER));
  assign rd_rxd = bus_rd && (bus_addr == AW'(A_RXD));
  assign rd_sr  = bus_rd && (bus_addr == AW'(A_SR));

  ctrl_t           cr_q;
  logic [SS_N-1:0] ss_q;
  logic            gie_q;
  logic [NIRQ-1:0] ie_q, is_q, ev;
  logic            modf_q, txh_q, rxf_q;
  logic [1:0]      sel_sync;
  logic            sel_n_s;

  // control, select, gate and enable registers
  always_ff @(posedge clk) begin
    if (rst_i) begin
      cr_q       <= '0;
      cr_q.inh   <= 1'b1;
      cr_q.manss <= 1'b1;
      ss_q       <= '1;
      gie_q      <= 1'b0;
      ie_q       <= '0;
    end else begin
      if (wr_cr) begin
        cr_q.en    <= bus_wdata[CB_EN];
        cr_q.mst   <= bus_wdata[CB_MST];
        cr_q.cpol  <= bus_wdata[CB_CPOL];
        cr_q.cpha  <= bus_wdata[CB_CPHA];
        cr_q.manss <= bus_wdata[CB_MANSS];
        cr_q.inh   <= bus_wdata[CB_INH];
        cr_q.lsb   <= bus_wdata[CB_LSB];
      end
      if (wr_ssr) ss_q  <= bus_wdata[SS_N-1:0];
      if (wr_gie) gie_q <= bus_wdata[31];
      if (wr_ier) ie_q  <= bus_wdata[NIRQ-1:0];
    end
  end

  // FIFOs
  logic          tx_clr, rx_clr;
  logic [DW-1:0] tx_dout, rx_dout, rx_word;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          sh_take, sh_done, sh_active, sh_busy, sh_go;

  assign tx_clr = wr_cr & bus_wdata[CB_TXRST];
  assign rx_clr = wr_cr & bus_wdata[CB_RXRST];

  spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst_i), .clr(tx_clr),
    .push(wr_txd), .din(bus_wdata[DW-1:0]),
    .pop(sh_take), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full), .count(tx_cnt)
  );

  spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst_i), .clr(rx_clr),
    .push(sh_done), .din(rx_word),
    .pop(rd_rxd), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full), .count(rx_cnt)
  );

  // shift engine
  assign sh_go = cr_q.en & cr_q.mst & ~cr_q.inh & ~tx_empty;

  logic sclk_w, mosi_w;
  spim_shift #(.DW(DW), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst_i),
    .go_i(sh_go), .word_i(tx_dout),
    .cpol_i(cr_q.cpol), .cpha_i(cr_q.cpha), .lsb_i(cr_q.lsb),
    .miso_i(miso),
    .take_o(sh_take), .done_o(sh_done), .rx_word_o(rx_word),
    .active_o(sh_active), .busy_o(sh_busy),
    .sclk_o(sclk_w), .mosi_o(mosi_w)
  );
  assign sclk = sclk_w;
  assign mosi = mosi_w;

  // slave selects
  logic [SS_N-1:0] ss_n_q;
  always_ff @(posedge clk) begin
    if (rst_i) ss_n_q <= '1;
    else       ss_n_q <= (cr_q.manss | sh_active) ? ss_q : '1;
  end
  assign ss_n = ss_n_q;

  // fault sense synchroniser
  always_ff @(posedge clk) begin
    if (rst_i) sel_sync <= 2'b11;
    else       sel_sync <= {sel_sync[0], sel_in_n};
  end
  assign sel_n_s = sel_sync[1];

  // interrupt events
  always_comb begin
    ev           = '0;
    ev[IB_MODF]  = cr_q.en & cr_q.mst & ~sel_n_s;
    ev[IB_SMODF] = ~cr_q.en & ~sel_n_s;
    ev[IB_TXE]   = sh_done & tx_empty;
    ev[IB_TXUR]  = 1'b0;
    ev[IB_RXF]   = rx_full & ~rxf_q;
    ev[IB_RXOV]  = sh_done & rx_full;
    ev[IB_TXHE]  = (tx_cnt <= CW'(HALF)) & ~txh_q;
  end

  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst_i) begin
      is_q   <= '0;
      modf_q <= 1'b0;
      txh_q  <= 1'b1;
      rxf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      is_q   <= (is_q & ~(wr_isr ? bus_wdata[NIRQ-1:0] : '0)) | ev;
      modf_q <= ev[IB_MODF] | (modf_q & ~rd_sr);
      txh_q  <= (tx_cnt <= CW'(HALF));
      rxf_q  <= rx_full;
      irq_q  <= gie_q & (|(is_q & ie_q));
    end
  end
  assign irq = irq_q;

  // registered read port
  logic [31:0] rd_q;
  always_ff @(posedge clk) begin
    if (rst_i) begin
      rd_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        AW'(A_CR):  rd_q <= {22'd0, cr_q.lsb, cr_q.inh, cr_q.manss, 2'b00,
                             cr_q.cpha, cr_q.cpol, cr_q.mst, cr_q.en, 1'b0};
        AW'(A_SR):  rd_q <= {27'd0, modf_q, tx_full, tx_empty, rx_full, rx_empty};
        AW'(A_RXD): rd_q <= rx_empty ? '0 : 32'(rx_dout);
        AW'(A_SSR): rd_q <= 32'(ss_q);
        AW'(A_GIE): rd_q <= {gie_q, 31'd0};
        AW'(A_ISR): rd_q <= 32'(is_q);
        AW'(A_IER): rd_q <= 32'(ie_q);
        default:    rd_q <= '0;
      endcase
    end
  end
  assign bus_rdata = rd_q;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[30:10], bus_wdata[0], rx_cnt};

  // R3: holding prevents an idle shifter from starting
  p_hold_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    (cr_q.inh && !sh_busy && !soft_q) |=> !sh_busy);

  // R12: a closed global gate keeps irq low
  p_gate_closed_r12: assert property (@(posedge clk) disable iff (rst)
    (!gie_q) |=> !irq);

  // R6: automatic select leaves the lines high around idle time
  p_auto_release_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!cr_q.manss) && $past(!sh_active)) |-> (&ss_n));
endmodule

// File: tb/test_spim_ctrl.sv
module test_spim_ctrl;
  localparam int DW      = 8;
  localparam int DEPTH   = 4;
  localparam int SS_N    = 4;
  localparam int CLK_DIV = 2;
  localparam int AW      = 8;

  localparam logic [7:0] O_GIE = 8'h1C, O_ISR = 8'h20, O_IER = 8'h28, O_SRST = 8'h40;
  localparam logic [7:0] O_CR = 8'h60, O_SR = 8'h64, O_TXD = 8'h68, O_RXD = 8'h6C, O_SSR = 8'h70;

  // stimulus table: [11] polarity [10] phase [9] lsb-first [8] invert MISO [7:0] word
  localparam int NV = 7;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0000, 8'hA5}, {4'b1000, 8'h3C}, {4'b0100, 8'h81}, {4'b1100, 8'h5E},
    {4'b0010, 8'h01}, {4'b1111, 8'hC6}, {4'b0011, 8'h70}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso, irq;
  logic sel_in_n = 1'b1;
  logic [SS_N-1:0] ss_n;
  logic inv_b = 1'b0;

  always #2.5 clk = ~clk;
  assign miso = mosi ^ inv_b;

  spim_ctrl #(.DW(DW), .DEPTH(DEPTH), .SS_N(SS_N), .CLK_DIV(CLK_DIV), .AW(AW)) i_spim_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .sel_in_n(sel_in_n), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done_f = 0;

  // serial monitor
  bit mon_on = 0;
  logic m_cpol = 1'b0, m_cpha = 1'b0;
  logic [DW-1:0] cap = '0;
  int nsamp = 0, nedge = 0, ss_rise = 0;

  always @(sclk) if (mon_on) begin
    nedge++;
    if ((sclk != m_cpol) != m_cpha) begin
      cap = {cap[DW-2:0], mosi};
      nsamp++;
    end
  end
  always @(posedge ss_n[1]) if (mon_on) ss_rise++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] rev(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  task automatic wrap_up();
    if (!done_f) begin
      done_f = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    wrap_up();
  end

  initial begin
    logic [31:0] d, base;
    logic [11:0] v;
    wait_n(5);
    rst = 1'b0;
    wait_n(2);

    // R1: reset state
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R1 ss_n", 32'(ss_n), 32'hF);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(O_CR, d);  chk("R1 ctrl", d, 32'h180);
    rd(O_SR, d);  chk("R1 status", d, 32'h05);
    rd(O_SSR, d); chk("R1 select", d, 32'hF);
    rd(O_ISR, d); chk("R1 flags", d, 32'h0);

    // R2: field readback, flush bits read 0, flush empties TX
    wr(O_CR, 32'h3FE);
    rd(O_CR, d); chk("R2 ctrl readback", d, 32'h39E);
    wr(O_CR, 32'h186);
    wr(O_TXD, 32'h12); wr(O_TXD, 32'h34);
    rd(O_SR, d); chk("R2 TX queued", d, 32'h01);
    wr(O_CR, 32'h1A6);
    rd(O_SR, d); chk("R2 TX flushed", d, 32'h05);
    rd(O_CR, d); chk("R2 flush reads 0", d, 32'h186);

    // R4 R5 R7: table of modes walked over the MOSI-to-MISO loop
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      base = 32'h186 | (32'(v[11]) << 3) | (32'(v[10]) << 4) | (32'(v[9]) << 9);
      wr(O_CR, base);
      wr(O_SSR, 32'hE);
      m_cpol = v[11]; m_cpha = v[10]; inv_b = v[8];
      wait_n(4);
      cap = '0; nsamp = 0; mon_on = 1;
      wr(O_TXD, 32'(v[7:0]));
      wr(O_CR, base & ~32'h100);
      wait_n(50);
      mon_on = 0;
      chk("R5 MOSI bit order", 32'(cap), 32'(v[9] ? rev(v[7:0]) : v[7:0]));
      chk("R4 samples per word", nsamp, DW);
      chk("R4 rest level", {31'd0, sclk}, 32'(v[11]));
      rd(O_RXD, d); chk("R4 R7 received word", d, 32'(v[7:0] ^ {DW{v[8]}}));
      wr(O_CR, base);
    end
    inv_b = 1'b0; m_cpol = 1'b0; m_cpha = 1'b0;

    // R3 R6 R8: hold, full TX, manual select
    wr(O_CR, 32'h186);
    wr(O_ISR, 32'h7F);
    wr(O_SSR, 32'hD);
    wait_n(3);
    nedge = 0; ss_rise = 0; mon_on = 1;
    wr(O_TXD, 32'h11); wr(O_TXD, 32'h22); wr(O_TXD, 32'h33);
    wr(O_TXD, 32'h44); wr(O_TXD, 32'h55);
    rd(O_SR, d); chk("R8 TX full status", d, 32'h09);
    wait_n(100);
    chk("R3 no edges while held", nedge, 0);
    chk("R6 manual select level", 32'(ss_n), 32'hD);
    wr(O_CR, 32'h086);
    wait_n(180);
    mon_on = 0;
    chk("R3 R8 edges for four words", nedge, 4 * 2 * DW);
    chk("R6 manual select never released", ss_rise, 0);
    rd(O_SR, d); chk("R8 RX full TX empty", d, 32'h06);
    rd(O_ISR, d); chk("R10 flags after burst", d, 32'h54);

    // R9: overrun keeps stored words
    wr(O_TXD, 32'h66);
    wait_n(45);
    rd(O_ISR, d); chk("R9 overrun flag", d, 32'h74);
    rd(O_RXD, d); chk("R9 R7 entry 0", d, 32'h11);
    rd(O_RXD, d); chk("R9 R7 entry 1", d, 32'h22);
    rd(O_RXD, d); chk("R9 R7 entry 2", d, 32'h33);
    rd(O_RXD, d); chk("R9 R7 entry 3", d, 32'h44);
    rd(O_RXD, d); chk("R7 empty read", d, 32'h0);
    rd(O_SR, d);  chk("R7 status after empty read", d, 32'h05);

    // R10: write one to clear
    wr(O_ISR, 32'h14);
    rd(O_ISR, d); chk("R10 partial clear", d, 32'h60);

    // R12: gating
    wr(O_IER, 32'h20);
    wait_n(3);
    chk("R12 gate closed", {31'd0, irq}, 32'd0);
    wr(O_GIE, 32'h8000_0000);
    wait_n(3);
    chk("R12 gate open", {31'd0, irq}, 32'd1);
    wr(O_ISR, 32'h20);
    wait_n(3);
    chk("R12 flag cleared", {31'd0, irq}, 32'd0);
    wr(O_ISR, 32'h7F);
    wr(O_GIE, 32'h0);

    // R11: TX-empty flag waits for the last word to finish
    wr(O_TXD, 32'hA1);
    wr(O_TXD, 32'hB2);
    wait_n(40);
    rd(O_ISR, d); chk("R11 no flag while last word in flight", d, 32'h0);
    rd(O_SR, d);  chk("R11 TX already empty", d, 32'h04);
    wait_n(40);
    rd(O_ISR, d); chk("R11 flag after last word", d, 32'h04);
    rd(O_RXD, d); chk("R7 burst word 0", d, 32'hA1);
    rd(O_RXD, d); chk("R7 burst word 1", d, 32'hB2);

    // R6: automatic select
    wr(O_CR, 32'h006);
    wait_n(3);
    chk("R6 auto idle high", 32'(ss_n), 32'hF);
    ss_rise = 0; mon_on = 1;
    wr(O_TXD, 32'h5A);
    wr(O_TXD, 32'hC3);
    wait_n(8);
    chk("R6 auto asserted in word", 32'(ss_n), 32'hD);
    wait_n(80);
    mon_on = 0;
    chk("R6 auto released per word", ss_rise, 2);
    chk("R6 auto high after burst", 32'(ss_n), 32'hF);
    rd(O_RXD, d); rd(O_RXD, d);

    // R13: keyed software reset
    wr(O_CR, 32'h18E);
    wr(O_SRST, 32'h05);
    wait_n(2);
    rd(O_CR, d); chk("R13 wrong key ignored", d, 32'h18E);
    wr(O_SRST, 32'h0A);
    wait_n(2);
    rd(O_CR, d);  chk("R13 ctrl reset", d, 32'h180);
    rd(O_SSR, d); chk("R13 select reset", d, 32'hF);

    // R14: fault sensing
    wr(O_CR, 32'h006);
    sel_in_n = 1'b0; wait_n(5); sel_in_n = 1'b1; wait_n(4);
    rd(O_SR, d);  chk("R14 status fault", d, 32'h15);
    rd(O_SR, d);  chk("R14 status fault cleared by read", d, 32'h05);
    rd(O_ISR, d); chk("R14 master fault flag", d, 32'h01);
    wr(O_ISR, 32'h01);
    wr(O_CR, 32'h000);
    sel_in_n = 1'b0; wait_n(5); sel_in_n = 1'b1; wait_n(4);
    rd(O_ISR, d); chk("R14 disabled fault flag", d, 32'h02);

    wrap_up();
  end
endmodule